// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

This block manages sixteen general-purpose pins behind a byte-wide register bus. For each pin, a control byte sets the direction, the output level, the drive type and the pull selection. These settings leave the block as plain control vectors for the pad ring. Incoming pin levels pass through a two-flop synchronizer. The synchronized level can be read back, and it feeds an edge detector whose sensitivity is set per pin.

Detected edges latch into pending bits. The pending bits are grouped as two eight-pin banks, each with its own status byte. Firmware acknowledges an event by writing the value it read back, because writing a one to a pending bit clears that bit. Each bank has an active-state mask byte, and together these mask bytes gate the pending bits onto one interrupt line. A second mask byte per bank exists for a low-power state. It is only stored and read back. One extra byte drives a dedicated panel-control output.

Top module: `gpioc_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, every control output is 0 and `irq_o` is low.
- R2: Pin p has an output-control byte at 0x2B+p (p<8) or 0x3B+(p-8) (p>=8), readable and writable as a whole byte. Bit 5 drives `pin_dir_o[p]` (1 = output), bit 4 drives `pin_od_o[p]` (1 = open-drain), bit 3 drives `pin_pull_en_o[p]`, bits 2:1 drive `pin_pull_sel_o[2p+1:2p]` (00 2k down, 01 2k up, 10 50k down, 11 50k up), and bit 0 drives `pin_out_o[p]`.
- R3: Pin p has an input-control byte at 0x33+p (p<8) or 0x43+(p-8). Bits 7:1 are writable and read back. Bit 0 is read-only and returns the synchronized pin level. A level applied before clock edge n becomes readable after edge n+1.
- R4: Bits 2:1 of the input-control byte select the edge mode: 00 none, 01 falling, 10 rising, 11 both. A qualifying level change applied before edge n sets the pin's pending bit at edge n+2. No other change sets it.
- R5: Pending bytes sit at 0x0B (pins 0-7) and 0x0C (pins 8-15), with bit = pin mod 8. Writing a 1 clears a bit, writing a 0 leaves it unchanged, and without writes or edges the bits hold.
- R6: If an edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: The active-state mask bytes are at 0x19 and 0x1A, where a 1 masks the pin. `irq_o` is high exactly when some pending bit is set and its mask bit is clear. Pending bits still latch while masked.
- R8: The second-state mask bytes at 0x1B and 0x1C are read/write storage and never affect `irq_o`.
- R9: The byte at 0x52 is read/write, and its bit 0 drives `panel_o` from the cycle after the write.
- R10: Reads of unmapped addresses return 0x00, `bus_rdata` is 0x00 while `bus_rd` is low, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is returned in the same cycle |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out_o | output | 16 | Output level per pin |
| pin_dir_o | output | 16 | Direction per pin (1 = output) |
| pin_od_o | output | 16 | Open-drain select per pin |
| pin_pull_en_o | output | 16 | Pull-resistor enable per pin |
| pin_pull_sel_o | output | 32 | Pull select, two bits per pin |
| panel_o | output | 1 | Panel-control output |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong pending or mask state appears on `irq_o` in the same cycle it arises. A wrong pending state also appears in the pending byte on the next read. A synchronizer or edge-mode fault shifts the cycle in which the pending bit appears, or stops it from appearing, so latency is checked to the exact edge. A wrong control byte shows at once on the pin control vectors. The bench runs a cycle-accurate model alongside the design and compares the outputs and a read of one address every cycle. Any divergence is therefore reported within one cycle of the point where it reaches a port.

// File: rtl/gpioc_pkg.sv
// Shared constants and types for the GPIO controller.
// Assumes eight pins per bank, so that one pending or mask byte covers one bank.
package gpioc_pkg;
    localparam int NPIN        = 16;
    localparam int NPB         = 8;
    localparam int AW          = 8;
    localparam int DW          = 8;
    localparam int OCW         = 6;   // output-control bits exported per pin
    localparam int CTL_STRIDE  = 16;  // distance between bank control bases
    localparam int STAT_STRIDE = 1;   // distance between bank status bytes

    localparam logic [AW-1:0] PEND_BASE  = 8'h0B;
    localparam logic [AW-1:0] MASK_BASE  = 8'h19;
    localparam logic [AW-1:0] MASKX_BASE = 8'h1B;
    localparam logic [AW-1:0] OCTL_BASE  = 8'h2B;
    localparam logic [AW-1:0] ICTL_BASE  = 8'h33;
    localparam logic [AW-1:0] PANEL_ADDR = 8'h52;

    // bit positions inside an output-control byte
    localparam int OC_VAL = 0;
    localparam int OC_PSL = 1;
    localparam int OC_PEN = 3;
    localparam int OC_OD  = 4;
    localparam int OC_DIR = 5;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/gpioc_sync.sv
// Two-flop synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent slow level; there is no bus coherency between bits.
module gpioc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg1;
    logic [W-1:0] stg2;

    // shift the raw levels through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= d;
            stg2 <= stg1;
        end
    end

    assign q = stg2;
endmodule

// File: rtl/gpioc_edge.sv
// Per-pin edge detector with a two-bit mode per pin.
// Assumes synchronized input; the pulse appears in the cycle after the level changes.
module gpioc_edge
    import gpioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [2*W-1:0] mode,
    output logic [W-1:0]   evt
);
    logic [W-1:0] prev;

    // remember the last synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_pin
        edge_mode_e m;
        logic       rise;
        logic       fall;
        assign m    = edge_mode_e'(mode[2*g +: 2]);
        assign rise = lvl[g] & ~prev[g];
        assign fall = ~lvl[g] & prev[g];
        // qualify the raw transitions with the selected mode
        always_comb begin
            unique case (m)
                EDGE_OFF:  evt[g] = 1'b0;
                EDGE_FALL: evt[g] = fall;
                EDGE_RISE: evt[g] = rise;
                EDGE_ANY:  evt[g] = rise | fall;
            endcase
        end
    end
endmodule

// File: rtl/gpioc_bank.sv
// One bank of pins: control bytes, pending byte, two mask bytes and the read mux.
// Assumes NPB == data width and a one-cycle write strobe; rdata is 0 for foreign addresses.
module gpioc_bank
    import gpioc_pkg::*;
#(
    parameter int              NB      = NPB,
    parameter logic [AW-1:0]   PEND_A  = PEND_BASE,
    parameter logic [AW-1:0]   MASK_A  = MASK_BASE,
    parameter logic [AW-1:0]   MASKX_A = MASKX_BASE,
    parameter logic [AW-1:0]   OCTL_A  = OCTL_BASE,
    parameter logic [AW-1:0]   ICTL_A  = ICTL_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr,
    input  logic [NB-1:0]     lvl,
    output logic [DW-1:0]     rdata,
    output logic              irq_req,
    output logic [NB*OCW-1:0] oc_flat
);
    localparam int IW    = $clog2(NB);
    localparam int OC_LO = int'(OCTL_A);
    localparam int IC_LO = int'(ICTL_A);

    logic [DW-1:0]   octl [NB];
    logic [DW-1:1]   ictl [NB];
    logic [NB-1:0]   pend;
    logic [NB-1:0]   mask;
    logic [NB-1:0]   maskx;
    logic [NB-1:0]   evt;
    logic [NB-1:0]   clr;
    logic [2*NB-1:0] mode_flat;
    logic            oc_hit;
    logic            ic_hit;
    logic [IW-1:0]   oc_idx;
    logic [IW-1:0]   ic_idx;

    assign oc_hit = (int'(addr) >= OC_LO) && (int'(addr) < OC_LO + NB);
    assign ic_hit = (int'(addr) >= IC_LO) && (int'(addr) < IC_LO + NB);
    assign oc_idx = IW'(addr - OCTL_A);
    assign ic_idx = IW'(addr - ICTL_A);

    for (genvar g = 0; g < NB; g++) begin : g_fan
        assign mode_flat[2*g +: 2]  = ictl[g][2:1];
        assign oc_flat[g*OCW +: OCW] = octl[g][OCW-1:0];
    end

    gpioc_edge #(.W(NB)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .mode  (mode_flat),
        .evt   (evt)
    );

    // control bytes: whole-byte writes by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                octl[i] <= '0;
                ictl[i] <= '0;
            end
        end else if (wr) begin
            if (oc_hit) octl[oc_idx] <= wdata;
            if (ic_hit) ictl[ic_idx] <= wdata[DW-1:1];
        end
    end

    // mask bytes: plain storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            maskx <= '0;
        end else if (wr) begin
            if (addr == MASK_A)  mask  <= wdata[NB-1:0];
            if (addr == MASKX_A) maskx <= wdata[NB-1:0];
        end
    end

    assign clr = (wr && addr == PEND_A) ? wdata[NB-1:0] : '0;

    // pending byte: write-one-to-clear, a new edge wins
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | evt;
    end

    // read mux for this bank's addresses
    always_comb begin
        rdata = '0;
        if (oc_hit)               rdata = octl[oc_idx];
        else if (ic_hit)          rdata = {ictl[ic_idx], lvl[ic_idx]};
        else if (addr == PEND_A)  rdata = DW'(pend);
        else if (addr == MASK_A)  rdata = DW'(mask);
        else if (addr == MASKX_A) rdata = DW'(maskx);
    end

    assign irq_req = |(pend & ~mask);

    // R5: a clearing write removes every bit not re-set by an edge
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == PEND_A) |=> ((pend & $past(wdata[NB-1:0] & ~evt)) == '0));

    // R5: without a write or an edge the pending byte holds
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && addr == PEND_A) && evt == '0) |=> $stable(pend));

    // R6: an edge always leaves its bit set, whatever the write did
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpioc_top.sv
// GPIO controller top: synchronizer, two pin banks, panel byte and interrupt merge.
// Assumes a single clock domain for the bus; pin inputs may be asynchronous.
module gpioc_top
    import gpioc_pkg::*;
#(
    parameter int NP = NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NP-1:0]   pin_in,
    output logic [NP-1:0]   pin_out_o,
    output logic [NP-1:0]   pin_dir_o,
    output logic [NP-1:0]   pin_od_o,
    output logic [NP-1:0]   pin_pull_en_o,
    output logic [2*NP-1:0] pin_pull_sel_o,
    output logic            panel_o,
    output logic            irq_o
);
    localparam int NBANK = NP / NPB;

    logic [NP-1:0]     lvl;
    logic [NP*OCW-1:0] oc_all;
    logic [DW-1:0]     bank_rd [NBANK];
    logic [NBANK-1:0]  irq_req;
    logic [DW-1:0]     panel_q;
    logic [DW-1:0]     rd_mux;

    gpioc_sync #(.W(NP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpioc_bank #(
            .NB      (NPB),
            .PEND_A  (PEND_BASE  + AW'(b * STAT_STRIDE)),
            .MASK_A  (MASK_BASE  + AW'(b * STAT_STRIDE)),
            .MASKX_A (MASKX_BASE + AW'(b * STAT_STRIDE)),
            .OCTL_A  (OCTL_BASE  + AW'(b * CTL_STRIDE)),
            .ICTL_A  (ICTL_BASE  + AW'(b * CTL_STRIDE))
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .wr      (bus_wr),
            .lvl     (lvl[b*NPB +: NPB]),
            .rdata   (bank_rd[b]),
            .irq_req (irq_req[b]),
            .oc_flat (oc_all[b*NPB*OCW +: NPB*OCW])
        );
    end

    for (genvar p = 0; p < NP; p++) begin : g_pinout
        assign pin_out_o[p]          = oc_all[p*OCW + OC_VAL];
        assign pin_pull_sel_o[2*p +: 2] = oc_all[p*OCW + OC_PSL +: 2];
        assign pin_pull_en_o[p]      = oc_all[p*OCW + OC_PEN];
        assign pin_od_o[p]           = oc_all[p*OCW + OC_OD];
        assign pin_dir_o[p]          = oc_all[p*OCW + OC_DIR];
    end

    // panel-control byte
    always_ff @(posedge clk) begin
        if (!rst_n)                               panel_q <= '0;
        else if (bus_wr && bus_addr == PANEL_ADDR) panel_q <= bus_wdata;
    end

    assign panel_o = panel_q[0];

    // merge bank read data; banks return zero for addresses they do not own
    always_comb begin
        rd_mux = (bus_addr == PANEL_ADDR) ? panel_q : '0;
        for (int b = 0; b < NBANK; b++) rd_mux = rd_mux | bank_rd[b];
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
    assign irq_o     = |irq_req;

    // R9: a panel write shows on the output in the next cycle
    p_panel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PANEL_ADDR) |=> (panel_o == $past(bus_wdata[0])));
endmodule

// File: tb/gpioc_top_bench.sv
module gpioc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out_o, pin_dir_o, pin_od_o, pin_pull_en_o;
    logic [31:0] pin_pull_sel_o;
    logic        panel_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpioc_top u_gpioc_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out_o(pin_out_o), .pin_dir_o(pin_dir_o), .pin_od_o(pin_od_o),
        .pin_pull_en_o(pin_pull_en_o), .pin_pull_sel_o(pin_pull_sel_o),
        .panel_o(panel_o), .irq_o(irq_o)
    );

    // reference model state
    logic [7:0]  m_octl [16];
    logic [7:0]  m_ictl [16];
    logic [7:0]  m_pend [2];
    logic [7:0]  m_mask [2];
    logic [7:0]  m_maskx [2];
    logic [7:0]  m_panel;
    logic [15:0] m_s1, m_s2, m_prev;
    logic [15:0] cur_pins = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ctl_pin(input logic [7:0] a, input int base0, input int base1);
        int ai = int'(a);
        if (ai >= base0 && ai < base0 + 8) return ai - base0;
        if (ai >= base1 && ai < base1 + 8) return 8 + ai - base1;
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        int p;
        p = ctl_pin(a, 8'h2B, 8'h3B);
        if (p >= 0) return m_octl[p];
        p = ctl_pin(a, 8'h33, 8'h43);
        if (p >= 0) return {m_ictl[p][7:1], m_s2[p]};
        case (a)
            8'h0B: return m_pend[0];
            8'h0C: return m_pend[1];
            8'h19: return m_mask[0];
            8'h1A: return m_mask[1];
            8'h1B: return m_maskx[0];
            8'h1C: return m_maskx[1];
            8'h52: return m_panel;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (ctl_pin(a, 8'h2B, 8'h3B) >= 0) return "R2 octl read";
        if (ctl_pin(a, 8'h33, 8'h43) >= 0) return "R3 ictl read";
        if (a == 8'h0B || a == 8'h0C) return "R5 pending read";
        if (a == 8'h19 || a == 8'h1A) return "R7 mask read";
        if (a == 8'h1B || a == 8'h1C) return "R8 maskx read";
        if (a == 8'h52) return "R9 panel read";
        return "R10 unmapped read";
    endfunction

    // advance the model by one clock edge using the inputs applied before it
    task automatic model_step(input logic [7:0] a, input logic [7:0] d, input logic w,
                              input logic [15:0] pins);
        logic [15:0] evt;
        int p;
        for (int i = 0; i < 16; i++) begin
            logic r, f;
            r = m_s2[i] & ~m_prev[i];
            f = ~m_s2[i] & m_prev[i];
            evt[i] = (m_ictl[i][2] & r) | (m_ictl[i][1] & f);
        end
        if (w) begin
            p = ctl_pin(a, 8'h2B, 8'h3B);
            if (p >= 0) m_octl[p] = d;
            p = ctl_pin(a, 8'h33, 8'h43);
            if (p >= 0) m_ictl[p] = d & 8'hFE;
            case (a)
                8'h0B: m_pend[0] = m_pend[0] & ~d;
                8'h0C: m_pend[1] = m_pend[1] & ~d;
                8'h19: m_mask[0] = d;
                8'h1A: m_mask[1] = d;
                8'h1B: m_maskx[0] = d;
                8'h1C: m_maskx[1] = d;
                8'h52: m_panel = d;
                default: ;
            endcase
        end
        m_pend[0] = m_pend[0] | evt[7:0];
        m_pend[1] = m_pend[1] | evt[15:8];
        m_prev = m_s2;
        m_s2 = m_s1;
        m_s1 = pins;
    endtask

    // one bus cycle: drive, check outputs and read data, then clock
    task automatic cyc(input logic [7:0] a, input logic [7:0] d, input logic w, input logic r);
        logic [15:0] e_out, e_dir, e_od, e_pen;
        logic [31:0] e_psel;
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; pin_in = cur_pins;
        #1;
        for (int p = 0; p < 16; p++) begin
            e_out[p] = m_octl[p][0];
            e_psel[2*p +: 2] = m_octl[p][2:1];
            e_pen[p] = m_octl[p][3];
            e_od[p]  = m_octl[p][4];
            e_dir[p] = m_octl[p][5];
        end
        chk(r ? req_of(a) : "R10 idle rdata", 32'(bus_rdata), r ? 32'(exp_rd(a)) : 32'h0);
        chk("R2 pin_out", 32'(pin_out_o), 32'(e_out));
        chk("R2 pin_dir", 32'(pin_dir_o), 32'(e_dir));
        chk("R2 pin_od", 32'(pin_od_o), 32'(e_od));
        chk("R2 pull_en", 32'(pin_pull_en_o), 32'(e_pen));
        chk("R2 pull_sel", pin_pull_sel_o, e_psel);
        chk("R9 panel_o", 32'(panel_o), 32'(m_panel[0]));
        chk("R7 irq_o", 32'(irq_o),
            32'(|((m_pend[0] & ~m_mask[0]) | (m_pend[1] & ~m_mask[1]))));
        @(posedge clk);
        model_step(a, d, w, cur_pins);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(a, d, 1'b1, 1'b0);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string req);
        bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1; pin_in = cur_pins;
        #1;
        chk(req, 32'(bus_rdata), 32'(e));
        cyc(a, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_octl[i] = '0; m_ictl[i] = '0; end
        for (int b = 0; b < 2; b++) begin m_pend[b] = '0; m_mask[b] = '0; m_maskx[b] = '0; end
        m_panel = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        chk("R1 dir after reset", 32'(pin_dir_o), 32'h0);
        rd_exp(8'h2B, 8'h00, "R1 octl reset");
        rd_exp(8'h0C, 8'h00, "R1 pending reset");
        rd_exp(8'h52, 8'h00, "R1 panel reset");

        // R2: control byte fields
        wr(8'h2E, 8'h3B);
        chk("R2 pin3 dir", 32'(pin_dir_o[3]), 32'h1);
        chk("R2 pin3 od", 32'(pin_od_o[3]), 32'h1);
        chk("R2 pin3 psel", 32'(pin_pull_sel_o[7:6]), 32'h1);
        wr(8'h3D, 8'h2C);
        chk("R2 pin10 psel", 32'(pin_pull_sel_o[21:20]), 32'h2);
        chk("R2 pin10 out", 32'(pin_out_o[10]), 32'h0);
        rd_exp(8'h3D, 8'h2C, "R2 pin10 readback");

        // R3/R4: rising mode on pin 2, exact latency
        wr(8'h35, 8'h04);
        cur_pins[2] = 1'b1;
        idle(1);
        rd_exp(8'h35, 8'h04, "R3 level not yet visible");
        rd_exp(8'h35, 8'h05, "R3 level after two edges");
        rd_exp(8'h0B, 8'h04, "R4 rising pending at edge n+2");
        chk("R7 irq pending unmasked", 32'(irq_o), 32'h1);

        // R7/R8: masking
        wr(8'h19, 8'h04);
        chk("R7 irq masked", 32'(irq_o), 32'h0);
        wr(8'h1B, 8'hFF);
        wr(8'h19, 8'h00);
        chk("R8 second mask no effect", 32'(irq_o), 32'h1);
        rd_exp(8'h1B, 8'hFF, "R8 second mask readback");

        // R5: write-one-to-clear
        wr(8'h0B, 8'h00);
        rd_exp(8'h0B, 8'h04, "R5 zero write keeps bit");
        wr(8'h0B, 8'h04);
        rd_exp(8'h0B, 8'h00, "R5 one write clears bit");
        chk("R7 irq low after clear", 32'(irq_o), 32'h0);

        // R4: falling mode on pin 9 ignores rise
        wr(8'h44, 8'h02);
        cur_pins[9] = 1'b1;
        idle(3);
        rd_exp(8'h0C, 8'h00, "R4 falling mode ignores rise");
        cur_pins[9] = 1'b0;
        idle(3);
        rd_exp(8'h0C, 8'h02, "R4 falling mode catches fall");
        wr(8'h0C, 8'hFF);

        // R4: disabled mode on pin 4
        cur_pins[4] = 1'b1;
        idle(3);
        rd_exp(8'h0B, 8'h00, "R4 disabled mode no pending");

        // R6: edge and clear in the same cycle
        cur_pins[2] = 1'b0;
        idle(3);
        cur_pins[2] = 1'b1;
        idle(2);
        wr(8'h0B, 8'h04);
        rd_exp(8'h0B, 8'h04, "R6 set wins over clear");
        wr(8'h0B, 8'h04);

        // R4: both edges on pin 15
        wr(8'h4A, 8'h06);
        cur_pins[15] = 1'b1;
        idle(3);
        rd_exp(8'h0C, 8'h80, "R4 both mode rise");
        wr(8'h0C, 8'h80);
        cur_pins[15] = 1'b0;
        idle(3);
        rd_exp(8'h0C, 8'h80, "R4 both mode fall");

        // R9: panel
        wr(8'h52, 8'h81);
        chk("R9 panel high", 32'(panel_o), 32'h1);
        rd_exp(8'h52, 8'h81, "R9 panel readback");

        // R10: unmapped writes and reads
        wr(8'h2A, 8'hFF); wr(8'h4B, 8'hFF); wr(8'h00, 8'hFF); wr(8'hFF, 8'hFF);
        rd_exp(8'h2A, 8'h00, "R10 unmapped read 0x2A");
        rd_exp(8'h4B, 8'h00, "R10 unmapped read 0x4B");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, d;
            int k;
            k = int'($urandom % 9);
            case (k)
                0: a = 8'h2B + 8'($urandom % 8);
                1: a = 8'h3B + 8'($urandom % 8);
                2: a = 8'h33 + 8'($urandom % 8);
                3: a = 8'h43 + 8'($urandom % 8);
                4: a = 8'h0B + 8'($urandom % 2);
                5: a = 8'h19 + 8'($urandom % 4);
                6: a = 8'h52;
                default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            if ($urandom % 4 == 0) cur_pins = cur_pins ^ 16'($urandom);
            cyc(a, d, ($urandom % 3) == 0, ($urandom % 2) == 0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule